// File: doc/BRIEF.md
# Cyclic Per-Queue Transmission Gate Controller

This block drives one open/closed gate for each egress queue of a port. Software loads an ordered schedule of entries. Each entry carries a gate mask and a hold time counted in clock ticks. While enabled, the controller plays the entries in index order. When the last entry of the schedule has run, it starts again at entry 0. The registered gate vector goes to a downstream transmission selector. That selector may pick frames only from queues whose gate bit is 1, and it holds back frames in queues whose bit is 0. A one-cycle pulse marks the start of every schedule cycle.

Two schedule banks exist. Writes always land in the bank that is not playing. A swap request is latched and is applied only at the next cycle start. A running schedule is therefore never torn.

Top module: `tgate_sched`

## Requirements
- R1: After a synchronous reset, `gate_open` is all ones and `cycle_start` is 0.
- R2: A clock edge that samples `enable` low sets `gate_open` to all ones and `cycle_start` to 0. An edge that samples `enable` high while the controller is stopped begins a cycle at entry 0.
- R3: Bit q of an entry's mask (1 = open) appears on `gate_open[q]` from the edge that loads the entry. It is held for exactly `interval` clock cycles.
- R4: An entry whose `interval` is 0 is held for exactly one clock cycle.
- R5: Entries play in increasing index order. The edge that ends an entry whose `last` flag is 1 starts a new cycle at entry 0.
- R6: If no entry up to index MAX_ENTRIES-1 has `last` set, the cycle ends after entry MAX_ENTRIES-1 and restarts at entry 0.
- R7: A write (`wr_en` high at an edge) stores `{wr_gates, wr_interval, wr_last}` at `wr_idx` of the bank not currently playing. It never changes the output of the playing schedule.
- R8: A `swap_req` pulse is remembered. At the next cycle start the other bank becomes the playing bank, and the request is then consumed. Without a pending request, a cycle start reuses the same bank.
- R9: `cycle_start` is high for exactly the one clock cycle after each edge that starts a cycle. This includes the start after `enable` rises.
- R10: If `enable` drops in the middle of a cycle and later returns, play restarts at entry 0. A swap requested while stopped applies at that restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the schedule; low forces all gates open |
| swap_req | input | 1 | Pulse: swap banks at the next cycle start |
| wr_en | input | 1 | Write one entry into the idle bank |
| wr_idx | input | IDX_W | Entry index to write |
| wr_gates | input | NUM_QUEUES | Gate mask of the entry, bit q = queue q |
| wr_interval | input | INTERVAL_W | Hold time in clock ticks (0 acts as 1) |
| wr_last | input | 1 | Entry ends the cycle |
| gate_open | output | NUM_QUEUES | Registered gate state per queue |
| cycle_start | output | 1 | One-cycle pulse at each cycle start |

## Verification
The bench builds the controller with four queues, four entries per bank and a six-bit interval. Four entries let a schedule without any `last` flag reach the wrap at the top index within a few cycles. Short intervals let many cycle starts, zero-length entries and bank swaps happen in a short run. A behavioural model of both banks, the pending swap and the remaining ticks runs beside the design. The model is compared with the design on every clock, across schedules that end on a `last` flag and schedules that wrap. The comparison also covers writes to the idle bank during play and a stop in the middle of a cycle.

// File: rtl/tgate_pkg.sv
package tgate_pkg;
  function automatic int unsigned idx_bits(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/tgate_list_mem.sv
module tgate_list_mem #(
  parameter int NUM_QUEUES  = 8,
  parameter int MAX_ENTRIES = 16,
  parameter int INTERVAL_W  = 16,
  localparam int IDX_W   = tgate_pkg::idx_bits(MAX_ENTRIES),
  localparam int ENTRY_W = NUM_QUEUES + INTERVAL_W + 1
) (
  input  logic                  clk,
  input  logic                  wr_en,
  input  logic                  wr_bank,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [NUM_QUEUES-1:0] wr_gates,
  input  logic [INTERVAL_W-1:0] wr_interval,
  input  logic                  wr_last,
  input  logic                  rd_bank,
  input  logic [IDX_W-1:0]      rd_idx,
  output logic [NUM_QUEUES-1:0] rd_gates,
  output logic [INTERVAL_W-1:0] rd_interval,
  output logic                  rd_last
);
  localparam int DEPTH = 2 * MAX_ENTRIES;

  logic [ENTRY_W-1:0] store [DEPTH];
  logic [ENTRY_W-1:0] rd_word;

  always_ff @(posedge clk) begin
    if (wr_en)
      store[{wr_bank, wr_idx}] <= {wr_gates, wr_interval, wr_last};
  end

  assign rd_word     = store[{rd_bank, rd_idx}];
  assign rd_gates    = rd_word[ENTRY_W-1 -: NUM_QUEUES];
  assign rd_interval = rd_word[INTERVAL_W:1];
  assign rd_last     = rd_word[0];
endmodule

// File: rtl/tgate_interval_timer.sv
module tgate_interval_timer #(
  parameter int INTERVAL_W = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [INTERVAL_W-1:0] load_val,
  output logic                  expired
);
  logic [INTERVAL_W-1:0] ticks_left;

  always_ff @(posedge clk) begin
    if (rst)
      ticks_left <= '0;
    else if (load)
      ticks_left <= (load_val == '0) ? '0 : load_val - 1'b1;
    else if (ticks_left != '0)
      ticks_left <= ticks_left - 1'b1;
  end

  assign expired = (ticks_left == '0);

  // R4: an idle counter at zero must stay at zero (no wrap-around)
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && ticks_left == '0) |=> (ticks_left == '0));
endmodule

// File: rtl/tgate_cycle_ctrl.sv
module tgate_cycle_ctrl #(
  parameter int NUM_QUEUES  = 8,
  parameter int MAX_ENTRIES = 16,
  localparam int IDX_W = tgate_pkg::idx_bits(MAX_ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic                  swap_req,
  input  logic                  expired,
  input  logic [NUM_QUEUES-1:0] rd_gates,
  input  logic                  rd_last,
  output logic                  rd_bank,
  output logic [IDX_W-1:0]      rd_idx,
  output logic                  load,
  output logic                  wr_bank,
  output logic [NUM_QUEUES-1:0] gate_open,
  output logic                  cycle_start
);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(MAX_ENTRIES - 1);

  logic             running;
  logic             active;
  logic             pending;
  logic             cur_last;
  logic [IDX_W-1:0] idx;
  logic             at_end;
  logic             begin_cycle;
  logic             step;

  assign at_end      = expired && (cur_last || idx == TOP_IDX);
  assign begin_cycle = enable && (!running || at_end);
  assign step        = enable && running && expired && !at_end;
  assign load        = begin_cycle || step;
  assign rd_bank     = begin_cycle ? (active ^ pending) : active;
  assign rd_idx      = begin_cycle ? '0 : idx + 1'b1;
  assign wr_bank     = ~active;

  always_ff @(posedge clk) begin
    if (rst) begin
      running     <= 1'b0;
      active      <= 1'b0;
      pending     <= 1'b0;
      cur_last    <= 1'b0;
      idx         <= '0;
      gate_open   <= '1;
      cycle_start <= 1'b0;
    end else begin
      pending <= (pending & ~begin_cycle) | swap_req;
      if (!enable) begin
        running     <= 1'b0;
        gate_open   <= '1;
        cycle_start <= 1'b0;
      end else if (load) begin
        running     <= 1'b1;
        active      <= rd_bank;
        idx         <= rd_idx;
        cur_last    <= rd_last;
        gate_open   <= rd_gates;
        cycle_start <= begin_cycle;
      end else begin
        cycle_start <= 1'b0;
      end
    end
  end

  assert_disabled_open_R2: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (&gate_open && !cycle_start));

  assert_hold_gates_R3: assert property (@(posedge clk) disable iff (rst)
    (enable && running && !expired) |=> $stable(gate_open));

  assert_bank_at_boundary_R8: assert property (@(posedge clk) disable iff (rst)
    !begin_cycle |=> $stable(active));

  assert_start_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(enable) |=> cycle_start);
endmodule

// File: rtl/tgate_sched.sv
module tgate_sched #(
  parameter int NUM_QUEUES  = 8,
  parameter int MAX_ENTRIES = 16,
  parameter int INTERVAL_W  = 16,
  localparam int IDX_W = tgate_pkg::idx_bits(MAX_ENTRIES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  enable,
  input  logic                  swap_req,
  input  logic                  wr_en,
  input  logic [IDX_W-1:0]      wr_idx,
  input  logic [NUM_QUEUES-1:0] wr_gates,
  input  logic [INTERVAL_W-1:0] wr_interval,
  input  logic                  wr_last,
  output logic [NUM_QUEUES-1:0] gate_open,
  output logic                  cycle_start
);
  logic                  rd_bank;
  logic [IDX_W-1:0]      rd_idx;
  logic [NUM_QUEUES-1:0] rd_gates;
  logic [INTERVAL_W-1:0] rd_interval;
  logic                  rd_last;
  logic                  wr_bank;
  logic                  load;
  logic                  expired;

  tgate_list_mem #(
    .NUM_QUEUES(NUM_QUEUES), .MAX_ENTRIES(MAX_ENTRIES), .INTERVAL_W(INTERVAL_W)
  ) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_idx(wr_idx),
    .wr_gates(wr_gates), .wr_interval(wr_interval), .wr_last(wr_last),
    .rd_bank(rd_bank), .rd_idx(rd_idx),
    .rd_gates(rd_gates), .rd_interval(rd_interval), .rd_last(rd_last)
  );

  tgate_interval_timer #(.INTERVAL_W(INTERVAL_W)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_val(rd_interval), .expired(expired)
  );

  tgate_cycle_ctrl #(.NUM_QUEUES(NUM_QUEUES), .MAX_ENTRIES(MAX_ENTRIES)) u_ctrl (
    .clk(clk), .rst(rst), .enable(enable), .swap_req(swap_req),
    .expired(expired), .rd_gates(rd_gates), .rd_last(rd_last),
    .rd_bank(rd_bank), .rd_idx(rd_idx), .load(load), .wr_bank(wr_bank),
    .gate_open(gate_open), .cycle_start(cycle_start)
  );

  // R7: a write must never target the bank that is being replayed
  assert_write_idle_bank_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !load) |-> (wr_bank != rd_bank));
endmodule

// File: tb/tgate_sched_test.sv
module tgate_sched_test;
  localparam int CLK_PERIOD = 10;
  localparam int NQ = 4;
  localparam int ME = 4;
  localparam int IW = 6;
  localparam int IXW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic swap_req = 1'b0;
  logic wr_en = 1'b0;
  logic [IXW-1:0] wr_idx = '0;
  logic [NQ-1:0] wr_gates = '0;
  logic [IW-1:0] wr_interval = '0;
  logic wr_last = 1'b0;
  logic [NQ-1:0] gate_open;
  logic cycle_start;

  int checks = 0;
  int errors = 0;
  string tag = "R1";

  tgate_sched #(.NUM_QUEUES(NQ), .MAX_ENTRIES(ME), .INTERVAL_W(IW)) uut (
    .clk(clk), .rst(rst), .enable(enable), .swap_req(swap_req),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_gates(wr_gates),
    .wr_interval(wr_interval), .wr_last(wr_last),
    .gate_open(gate_open), .cycle_start(cycle_start)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // behavioural reference model
  int mg [2][ME];
  int mi [2][ME];
  int ml [2][ME];
  int m_run = 0, m_bank = 0, m_pend = 0, m_idx = 0, m_left = 0, m_last = 0;
  int exp_gates = 15, exp_pulse = 0;
  bit model_live = 0;
  int starts = 0;

  always @(posedge clk) begin
    int ob, st, sp, nb;
    ob = m_bank;
    if (rst) begin
      m_run = 0; m_bank = 0; m_pend = 0; m_idx = 0; m_left = 0; m_last = 0;
      exp_gates = 15; exp_pulse = 0; model_live = 1;
    end else begin
      st = (enable && (!m_run || (m_left == 0 && (m_last || m_idx == ME - 1)))) ? 1 : 0;
      sp = (enable && m_run && m_left == 0 && !st) ? 1 : 0;
      if (!enable) begin
        m_run = 0; exp_gates = 15; exp_pulse = 0;
        if (m_left > 0) m_left--;
      end else if (st || sp) begin
        nb = st ? (m_bank ^ m_pend) : m_bank;
        m_idx = st ? 0 : m_idx + 1;
        m_bank = nb;
        exp_gates = mg[nb][m_idx];
        m_last = ml[nb][m_idx];
        m_left = (mi[nb][m_idx] == 0) ? 0 : mi[nb][m_idx] - 1;
        exp_pulse = st;
        m_run = 1;
        if (st) starts++;
      end else begin
        exp_pulse = 0;
        if (m_left > 0) m_left--;
      end
      m_pend = ((m_pend && !st) || swap_req) ? 1 : 0;
      if (wr_en) begin
        mg[ob ^ 1][wr_idx] = wr_gates;
        mi[ob ^ 1][wr_idx] = wr_interval;
        ml[ob ^ 1][wr_idx] = wr_last;
      end
    end
  end

  task automatic check(string req, int act, int expv, string what);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, expv, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_live) begin
      check(tag, int'(gate_open), exp_gates, "gate_open");
      check(tag, int'(cycle_start), exp_pulse, "cycle_start");
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_entry(int i, int g, int iv, int last);
    wr_idx = IXW'(i); wr_gates = NQ'(g); wr_interval = IW'(iv);
    wr_last = last[0]; wr_en = 1'b1;
    tick(1);
    wr_en = 1'b0;
  endtask

  task automatic pulse_swap();
    swap_req = 1'b1;
    tick(1);
    swap_req = 1'b0;
  endtask

  initial begin
    int s0;
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < ME; i++) begin
        mg[b][i] = 0; mi[b][i] = 0; ml[b][i] = 0;
      end
    tick(3);
    tag = "R1";
    check("R1", int'(gate_open), 15, "reset gates");
    check("R1", int'(cycle_start), 0, "reset pulse");
    rst = 1'b0;
    tick(2);

    // R3 R4 R5: last-flag terminated schedule, one zero interval
    tag = "R3";
    write_entry(0, 5, 3, 0);
    write_entry(1, 2, 0, 0);
    write_entry(2, 8, 2, 1);
    pulse_swap();
    tick(2);
    check("R2", int'(gate_open), 15, "still disabled");
    enable = 1'b1;
    tick(1);
    tag = "R9";
    check("R9", int'(cycle_start), 1, "pulse after enable");
    check("R3", int'(gate_open), 5, "entry0 mask");
    tick(3);
    tag = "R4";
    check("R4", int'(gate_open), 2, "zero-interval entry");
    tick(1);
    check("R5", int'(gate_open), 8, "entry2 mask");
    tick(2);
    tag = "R5";
    check("R5", int'(gate_open), 5, "restart at entry0");
    check("R9", int'(cycle_start), 1, "boundary pulse");
    tick(20);

    // R7: write idle bank while running, R6 wrap schedule
    tag = "R7";
    write_entry(0, 1, 1, 0);
    write_entry(1, 3, 2, 0);
    write_entry(2, 12, 0, 0);
    write_entry(3, 6, 1, 0);
    tick(12);
    // R8: swap at the next boundary
    tag = "R8";
    pulse_swap();
    tick(14);
    tag = "R6";
    s0 = starts;
    tick(15);
    check("R6", (starts - s0 >= 2) ? 1 : 0, 1, "wrap restarts seen");

    // R10: disable mid-cycle, swap while stopped, re-enable
    tag = "R10";
    tick(2);
    enable = 1'b0;
    tick(1);
    check("R2", int'(gate_open), 15, "gates open when disabled");
    write_entry(0, 9, 2, 0);
    write_entry(1, 4, 1, 1);
    pulse_swap();
    tick(3);
    enable = 1'b1;
    tick(1);
    check("R10", int'(gate_open), 9, "restart at entry0 of swapped bank");
    check("R10", int'(cycle_start), 1, "restart pulse");
    tick(20);
    tag = "R2";
    enable = 1'b0;
    tick(3);
    check("R2", int'(gate_open), 15, "final disabled state");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule